// File: doc/BRIEF.md
# UART Receive-FIFO Interrupt Register Block

This block is the register and buffering side of a classic 16550-style UART. A processor reaches it through a byte-wide port with a 3-bit register index, one-cycle read and write strobes, 8-bit write data and 8-bit read data. Through this port software sets the line format, programs a 16-bit baud divisor, enables the receive interrupt, picks a receive trigger level, identifies the pending interrupt cause and polls line status.

On the serial side, a deserializer presents each received byte with a one-cycle valid strobe. The byte goes into a receive FIFO. A serializer takes transmit bytes from a one-byte holding register through a valid/ready handshake. The block also produces the oversampling tick that both shifters use.

The receive interrupt has two causes. The first is the FIFO fill reaching the programmed trigger level. The second is a non-empty FIFO that has seen neither a new byte nor a read for four character times. Setting bit 7 of the line control register turns offsets 0 and 1 into the low and high divisor bytes.

Top module: `uart_ctrl_regs`

## Requirements
- R1: After reset, the registers read as follows: line control (offset 3) 0x03, interrupt enable (offset 1) 0x00, interrupt identification (offset 2) 0xC1 and line status (offset 5) 0x60. The irq output is low.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. While that bit is 0, offset 1 reads and writes the interrupt enable register (bits 3:0), and writing the divisor leaves it unchanged.
- R3: baud_tick pulses once every D clock cycles, where D is the 16-bit divisor. A divisor of 0 stops the ticks.
- R4: Line status bit 0 is 1 exactly while the receive FIFO holds data. A read of offset 0 with line control bit 7 clear returns the oldest byte and removes it, so bytes come out in arrival order.
- R5: A write to offset 2 sets the trigger level from data bits 7:6: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. When enable bit 0 is set and the fill is at or above the trigger, irq is 1 and offset 2 reads 0xC4.
- R6: With enable bit 0 set and the FIFO non-empty but below the trigger, irq rises and offset 2 reads 0xCC once 4 × TICKS_PER_CHAR baud ticks pass with no received byte and no FIFO read. Each received byte or read restarts the count.
- R7: With enable bit 0 clear, irq stays 0 whatever the FIFO holds. With nothing pending, offset 2 reads 0xC1.
- R8: A byte that arrives while the FIFO holds FIFO_DEPTH bytes is dropped, and line status bit 1 is set. Reading line status returns the bit as 1 and then clears it.
- R9: A write to offset 2 with data bit 1 set empties the receive FIFO and cancels any pending timeout.
- R10: A write to offset 0 with line control bit 7 clear loads the transmit holding register. tx_valid is then held with a stable tx_data until tx_ready is seen. Writes made while it is full are ignored. Line status bits 5 and 6 are 1 while it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of reg_rd |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit holding register is full |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| baud_tick | output | 1 | Oversampling tick from the divisor |
| irq | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach from the ports is the character timeout. It needs a FIFO that stays below its trigger and untouched for hundreds of baud ticks. It also has to be shown that a new byte partway through the wait really restarts the count. The stimulus first sets the divisor to 1, so one tick falls in each clock. It then checks irq shortly before and shortly after the 640-tick window. A second byte pushed in mid-window shifts that window, and the check confirms the expiry moves with it. Overrun is reached by filling all sixteen entries with a gap-free byte stream and then sending one more byte.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_ID   = 3'd2;
  localparam logic [2:0] OFS_LINE = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd5;

  localparam logic [3:0] ID_NONE    = 4'h1;
  localparam logic [3:0] ID_RX_LVL  = 4'h4;
  localparam logic [3:0] ID_RX_IDLE = 4'hC;

  localparam logic [7:0] LINE_RESET = 8'h03;

  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, wr_inc, rd_inc;
  logic [CW-1:0] cnt_q, cnt_d;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_inc = wr_ptr_q + 1'b1;
      assign rd_inc = rd_ptr_q + 1'b1;
    end else begin : g_wrap
      assign wr_inc = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_inc = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;
  assign dout  = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_ptr_d = wr_inc;
      if (pop)  rd_ptr_d = rd_inc;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr_q] <= din;
  end

endmodule

// File: rtl/ubaud_gen.sv
module ubaud_gen #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] divisor,
  input  logic          restart,
  output logic          tick
);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          run;

  assign run  = (divisor != '0);
  assign tick = run && (cnt_q == divisor - 1'b1);

  always_comb begin
    if (restart || !run || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/urx_timeout.sv
module urx_timeout #(
  parameter int LIMIT = 640,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic active,
  output logic expired
);

  logic [TW-1:0] timer_q, timer_d;
  logic          flag_q, flag_d;

  always_comb begin
    timer_d = timer_q;
    flag_d  = flag_q;
    if (restart || !active) begin
      timer_d = '0;
      flag_d  = 1'b0;
    end else if (tick && !flag_q) begin
      if (timer_q == TW'(LIMIT - 1)) flag_d  = 1'b1;
      else                           timer_d = timer_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      timer_q <= timer_d;
      flag_q  <= flag_d;
    end
  end

  assign expired = flag_q;

endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_regs_pkg::*;
#(
  parameter int          FIFO_DEPTH     = 16,
  parameter int          TICKS_PER_CHAR = 160,
  parameter int          TIMEOUT_CHARS  = 4,
  parameter logic [15:0] DIV_RESET      = 16'd27
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       baud_tick,
  output logic       irq
);

  localparam int CW    = $clog2(FIFO_DEPTH + 1);
  localparam int LIMIT = TICKS_PER_CHAR * TIMEOUT_CHARS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // architectural state
  logic [7:0]  lcr_q, lcr_d;
  logic [3:0]  ier_q, ier_d;
  logic [1:0]  trig_q, trig_d;
  logic [7:0]  dll_q, dll_d, dlm_q, dlm_d;
  logic        ovr_q, ovr_d;
  logic        thr_full_q, thr_full_d;
  logic [7:0]  thr_q, thr_d;

  // access decode
  logic dlab;
  logic wr_thr, wr_dll, wr_ier, wr_dlm, wr_fcr, wr_lcr;
  logic rd_rbr, rd_lsr;
  assign dlab   = lcr_q[7];
  assign wr_thr = reg_wr && reg_addr == OFS_DATA && !dlab;
  assign wr_dll = reg_wr && reg_addr == OFS_DATA &&  dlab;
  assign wr_ier = reg_wr && reg_addr == OFS_IEN  && !dlab;
  assign wr_dlm = reg_wr && reg_addr == OFS_IEN  &&  dlab;
  assign wr_fcr = reg_wr && reg_addr == OFS_ID;
  assign wr_lcr = reg_wr && reg_addr == OFS_LINE;
  assign rd_rbr = reg_rd && reg_addr == OFS_DATA && !dlab;
  assign rd_lsr = reg_rd && reg_addr == OFS_STAT;

  // receive path
  logic          fifo_clr, fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [7:0]    fifo_dout;
  logic [CW-1:0] fifo_cnt;
  assign fifo_clr  = wr_fcr && reg_wdata[1];
  assign fifo_push = rx_valid && !fifo_full;
  assign fifo_pop  = rd_rbr && !fifo_empty;

  urx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) i_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (fifo_clr),
    .push  (fifo_push),
    .din   (rx_data),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .count (fifo_cnt),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  logic [15:0] divisor;
  assign divisor = {dlm_q, dll_q};

  ubaud_gen #(.DW(16)) i_baud (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .divisor (divisor),
    .restart (wr_dll || wr_dlm),
    .tick    (baud_tick)
  );

  logic to_flag;
  urx_timeout #(.LIMIT(LIMIT)) i_timeout (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (baud_tick),
    .restart (fifo_push || fifo_pop || fifo_clr),
    .active  (!fifo_empty),
    .expired (to_flag)
  );

  // interrupt cause
  logic       lvl_hit, irq_lvl, irq_idle;
  logic [3:0] id_code;
  assign lvl_hit  = int'(fifo_cnt) >= int'(trig_bytes(trig_q));
  assign irq_lvl  = ier_q[0] && lvl_hit;
  assign irq_idle = ier_q[0] && to_flag && !fifo_empty;
  assign irq      = irq_lvl || irq_idle;

  always_comb begin
    if (irq_lvl)       id_code = ID_RX_LVL;
    else if (irq_idle) id_code = ID_RX_IDLE;
    else               id_code = ID_NONE;
  end

  // next state
  always_comb begin
    lcr_d      = lcr_q;
    ier_d      = ier_q;
    trig_d     = trig_q;
    dll_d      = dll_q;
    dlm_d      = dlm_q;
    ovr_d      = ovr_q;
    thr_full_d = thr_full_q;
    thr_d      = thr_q;
    if (wr_lcr) lcr_d  = reg_wdata;
    if (wr_ier) ier_d  = reg_wdata[3:0];
    if (wr_fcr) trig_d = reg_wdata[7:6];
    if (wr_dll) dll_d  = reg_wdata;
    if (wr_dlm) dlm_d  = reg_wdata;
    if (rx_valid && fifo_full) ovr_d = 1'b1;
    else if (rd_lsr)           ovr_d = 1'b0;
    if (thr_full_q) begin
      if (tx_ready) thr_full_d = 1'b0;
    end else if (wr_thr) begin
      thr_full_d = 1'b1;
      thr_d      = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lcr_q      <= LINE_RESET;
      ier_q      <= '0;
      trig_q     <= '0;
      dll_q      <= DIV_RESET[7:0];
      dlm_q      <= DIV_RESET[15:8];
      ovr_q      <= 1'b0;
      thr_full_q <= 1'b0;
      thr_q      <= '0;
    end else begin
      lcr_q      <= lcr_d;
      ier_q      <= ier_d;
      trig_q     <= trig_d;
      dll_q      <= dll_d;
      dlm_q      <= dlm_d;
      ovr_q      <= ovr_d;
      thr_full_q <= thr_full_d;
      thr_q      <= thr_d;
    end
  end

  assign tx_valid = thr_full_q;
  assign tx_data  = thr_q;

  // read data
  logic [7:0] lsr;
  assign lsr = {1'b0, !thr_full_q, !thr_full_q, 3'b000, ovr_q, !fifo_empty};

  always_comb begin
    case (reg_addr)
      OFS_DATA: reg_rdata = dlab ? dll_q : (fifo_empty ? 8'h00 : fifo_dout);
      OFS_IEN:  reg_rdata = dlab ? dlm_q : {4'h0, ier_q};
      OFS_ID:   reg_rdata = {4'hC, id_code};
      OFS_LINE: reg_rdata = lcr_q;
      OFS_STAT: reg_rdata = lsr;
      default:  reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/uart_ctrl_regs_chk.sv
module uart_ctrl_regs_chk #(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    reg_addr,
  input logic          reg_rd,
  input logic          dlab,
  input logic          rx_valid,
  input logic [CW-1:0] fifo_cnt,
  input logic          ovr_q,
  input logic [3:0]    ier_q,
  input logic          irq,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_ready,
  input logic [15:0]   divisor,
  input logic          baud_tick,
  input logic          to_flag,
  input logic          fifo_empty
);

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && fifo_cnt == CW'(FIFO_DEPTH) |=> ovr_q);

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_q[0] |-> !irq);

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick && divisor > 16'd1 |=> !baud_tick);

  // R4
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 3'd0 && !dlab && fifo_cnt != '0 && !rx_valid
      |=> fifo_cnt == $past(fifo_cnt) - 1'b1);

  // R6
  timeout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> !fifo_empty);

endmodule

bind uart_ctrl_regs uart_ctrl_regs_chk #(.FIFO_DEPTH(FIFO_DEPTH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_rd     (reg_rd),
  .dlab       (dlab),
  .rx_valid   (rx_valid),
  .fifo_cnt   (fifo_cnt),
  .ovr_q      (ovr_q),
  .ier_q      (ier_q),
  .irq        (irq),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_ready   (tx_ready),
  .divisor    (divisor),
  .baud_tick  (baud_tick),
  .to_flag    (to_flag),
  .fifo_empty (fifo_empty)
);

// File: tb/test_uart_ctrl_regs.sv
module test_uart_ctrl_regs;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       baud_tick;
  logic       irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_ctrl_regs i_uart_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .baud_tick(baud_tick), .irq(irq)
  );

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    if (reg_rd) begin
      if (sb_q.size() == 0) begin
        check("scoreboard read without expectation", 1, 0);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(it.tag, int'(reg_rdata), int'(it.exp));
      end
    end
  end

  task automatic reg_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_item_t it;
    it.tag = tag;
    it.exp = exp;
    sb_q.push_back(it);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(posedge clk); #1;
    rx_data = d; rx_valid = 1'b1;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic check_irq(input logic exp, input string tag);
    @(negedge clk);
    check(tag, int'(irq), int'(exp));
  endtask

  task automatic count_ticks(input int cycles, input int exp, input string tag);
    int n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
    check(tag, n, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset values
    reg_read(3'd3, 8'h03, "R1 line control reset");
    reg_read(3'd1, 8'h00, "R1 enable reset");
    reg_read(3'd2, 8'hC1, "R1 ident reset");
    reg_read(3'd5, 8'h60, "R1 status reset");
    check_irq(1'b0, "R1 irq reset");

    // R2 divisor latch access
    reg_write(3'd1, 8'h05);
    reg_write(3'd3, 8'h83);
    reg_write(3'd0, 8'h01);
    reg_write(3'd1, 8'h02);
    reg_read(3'd0, 8'h01, "R2 divisor low");
    reg_read(3'd1, 8'h02, "R2 divisor high");
    reg_write(3'd1, 8'h00);
    reg_write(3'd3, 8'h03);
    reg_read(3'd1, 8'h05, "R2 enable kept across divisor writes");
    reg_write(3'd1, 8'h00);

    // R3 baud tick spacing
    count_ticks(20, 20, "R3 divisor 1");
    reg_write(3'd3, 8'h83);
    reg_write(3'd0, 8'h03);
    count_ticks(30, 10, "R3 divisor 3");
    reg_write(3'd0, 8'h00);
    count_ticks(30, 0, "R3 divisor 0");
    reg_write(3'd0, 8'h01);
    reg_write(3'd3, 8'h03);

    // R4 / R7 ordering, data ready, masked irq
    rx_push(8'hA1); rx_push(8'hA2); rx_push(8'hA3);
    reg_read(3'd5, 8'h61, "R4 data ready set");
    check_irq(1'b0, "R7 irq masked");
    reg_read(3'd2, 8'hC1, "R7 ident none while masked");
    reg_read(3'd0, 8'hA1, "R4 first byte");
    reg_read(3'd0, 8'hA2, "R4 second byte");
    reg_read(3'd0, 8'hA3, "R4 third byte");
    reg_read(3'd5, 8'h60, "R4 data ready clear");

    // R5 trigger level 4
    reg_write(3'd2, 8'h40);
    reg_write(3'd1, 8'h01);
    rx_push(8'h11); rx_push(8'h12); rx_push(8'h13);
    check_irq(1'b0, "R5 below level 4");
    rx_push(8'h14);
    check_irq(1'b1, "R5 at level 4");
    reg_read(3'd2, 8'hC4, "R5 ident level");
    reg_read(3'd0, 8'h11, "R5 pop");
    check_irq(1'b0, "R5 below level after pop");
    // R9 clear
    reg_write(3'd2, 8'h42);
    reg_read(3'd5, 8'h60, "R9 fifo emptied");

    // R5 trigger level 8
    reg_write(3'd2, 8'h80);
    for (int i = 0; i < 7; i++) rx_push(8'(i));
    check_irq(1'b0, "R5 below level 8");
    rx_push(8'h07);
    check_irq(1'b1, "R5 at level 8");
    reg_write(3'd2, 8'h82);
    check_irq(1'b0, "R9 clear drops level irq");

    // R6 character timeout
    reg_write(3'd2, 8'h40);
    rx_push(8'h55);
    repeat (600) @(posedge clk);
    check_irq(1'b0, "R6 before timeout");
    repeat (100) @(posedge clk);
    check_irq(1'b1, "R6 after timeout");
    reg_read(3'd2, 8'hCC, "R6 ident timeout");
    reg_read(3'd0, 8'h55, "R6 drain");
    check_irq(1'b0, "R6 cleared by read");
    reg_read(3'd2, 8'hC1, "R7 ident none");
    rx_push(8'h61);
    repeat (500) @(posedge clk);
    rx_push(8'h62);
    repeat (500) @(posedge clk);
    check_irq(1'b0, "R6 restarted by new byte");
    repeat (200) @(posedge clk);
    check_irq(1'b1, "R6 timeout after restart");
    reg_write(3'd2, 8'h42);
    check_irq(1'b0, "R9 clear cancels timeout");

    // R8 overrun
    reg_write(3'd1, 8'h00);
    for (int i = 0; i < 16; i++) rx_push(8'(8'h80 + i));
    reg_read(3'd5, 8'h61, "R8 full no overrun");
    rx_push(8'hEE);
    reg_read(3'd5, 8'h63, "R8 overrun flagged");
    reg_read(3'd5, 8'h61, "R8 overrun cleared by read");
    for (int i = 0; i < 16; i++) reg_read(3'd0, 8'(8'h80 + i), "R8 stored bytes kept");
    reg_read(3'd5, 8'h60, "R8 empty after drain");

    // R10 transmit holding register
    reg_write(3'd0, 8'h5A);
    @(negedge clk);
    check("R10 tx_valid", int'(tx_valid), 1);
    check("R10 tx_data", int'(tx_data), 8'h5A);
    reg_read(3'd5, 8'h00, "R10 status busy");
    reg_write(3'd0, 8'h77);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 held data ignores write", int'(tx_data), 8'h5A);
    @(posedge clk); #1 tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    @(negedge clk);
    check("R10 tx_valid drops", int'(tx_valid), 0);
    reg_read(3'd5, 8'h60, "R10 status empty");

    repeat (2) @(posedge clk);
    check("scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule